// File: doc/BRIEF.md
# Acknowledged Transmit Retry Controller

This block runs the transmit side of a packet radio link that expects an acknowledgement for each packet. When transmission is enabled and a payload waits at the head of the transmit queue, it tells the modem to send that payload. It then turns the link round at once to listen. It accepts an acknowledgement only when the acknowledgement carries the address the packet was sent to.

If no acknowledgement arrives within the configured listening window, the same payload is sent again. This repeats until the configured number of retries has been used up. A confirmed acknowledgement removes the payload from the queue and raises a sent flag. Running out of retries raises a max-retry flag instead. In that case the payload stays in the queue, and no new transmission starts until software clears that flag.

Both flags are write-1-to-clear and drive an active-low interrupt line. When auto-acknowledge is switched off, each packet counts as sent as soon as the modem reports the end of transmission. RF modulation, CRC and the serial register interface sit outside this block.

Top module: `arq_tx_ctrl`

## Requirements
- R1: From idle, `modem_send` pulses high for one cycle when `tx_enable` is 1, `head_valid` is 1 and `flag_maxrt` is 0. No send starts while `tx_enable` is 0 or the queue is empty.
- R2: With `autoack_en` = 1, `listen_on` rises in the cycle after `modem_done`. With no acknowledgement it stays high for exactly (`cfg_retry_delay`+1)·`TICKS_PER_UNIT` cycles.
- R3: An acknowledgement is accepted only while `listen_on` is 1 with `ack_valid` = 1 and `ack_addr` equal to `tx_addr`. An acknowledgement with any other address has no effect on flags, pops or the retry sequence.
- R4: An accepted acknowledgement pulses `fifo_pop` for one cycle and sets `flag_sent`. This happens at the same clock edge, and `listen_on` drops.
- R5: When a listening window ends without an acknowledgement and retries remain, the same payload is sent again without popping. At most `cfg_retry_count`+1 sends are made per payload.
- R6: When the window after the last allowed send ends without an acknowledgement, `flag_maxrt` is set and nothing is popped. `cfg_retry_count` = 0 allows a single send.
- R7: While `flag_maxrt` is 1, no send starts, even with `tx_enable` = 1 and a queued payload. Once it is cleared, the kept payload is sent again.
- R8: `irq_n` is 0 whenever `flag_sent` or `flag_maxrt` is 1, and 1 otherwise.
- R9: A 1 on `clr_sent` (bit 0 of the flag set) or `clr_maxrt` (bit 1) clears that flag alone at the next edge.
- R10: With `autoack_en` = 0, `modem_done` immediately pops the payload and sets `flag_sent`. No listening window is opened.
- R11: After a successful send, if `tx_enable` is still 1 and more payloads are queued, the next packet starts with no further command.
- R12: The retry count starts again from zero for each newly popped payload and after each max-retry event. Every fresh attempt sequence therefore gets the full `cfg_retry_count`+1 sends.
- R13: While reset (`rst_n` = 0, synchronous) is held, both flags are 0, `irq_n` is 1, and `modem_send`, `listen_on` and `fifo_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Permits new packets to start |
| autoack_en | input | 1 | 1: wait for acknowledgement after each send |
| head_valid | input | 1 | Transmit queue holds at least one payload |
| fifo_pop | output | 1 | Remove head payload (one-cycle pulse) |
| tx_addr | input | ADDR_W | Destination address of the packet |
| modem_send | output | 1 | Start sending the head payload (pulse) |
| modem_done | input | 1 | Modem finished sending (pulse) |
| listen_on | output | 1 | Receiver enabled to wait for acknowledgement |
| ack_valid | input | 1 | A packet was received during listening |
| ack_addr | input | ADDR_W | Address carried by the received packet |
| cfg_retry_delay | input | 4 | Listening window in units minus one |
| cfg_retry_count | input | 4 | Number of resends allowed (0 = none) |
| clr_sent | input | 1 | Write-1-to-clear for the sent flag |
| clr_maxrt | input | 1 | Write-1-to-clear for the max-retry flag |
| flag_sent | output | 1 | Payload acknowledged (or sent without ack) |
| flag_maxrt | output | 1 | Retry limit reached, payload kept |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach from the ports is a max-retry stall that ends well. It needs a payload that has used up every resend, a queue that still looks non-empty and an enable held high. Software must then clear the flag, and the kept payload must go out again with a fresh retry budget. The stimulus plays both the modem and the far end. Its random trials draw the window length, the retry limit and the attempt on which an acknowledgement appears (or none at all), and they sometimes send a decoy acknowledgement with a wrong address. Every trial that ends in max-retry then holds enable high to check for the stall, clears the flag and completes the payload. Directed cases cover a retry limit of zero, a repeated limit event, disabled acknowledgement and a chained queue of three payloads.

// File: rtl/arq_pkg.sv
// Package: shared types and constants for the acknowledged transmit controller.
// Assumes: nothing beyond SystemVerilog 2017.
package arq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_AIR    = 2'd2,
        ST_LISTEN = 2'd3
    } arq_state_e;

    localparam int FLAG_NUM   = 2;
    localparam int FLAG_SENT  = 0;
    localparam int FLAG_MAXRT = 1;
endpackage

// File: rtl/arq_window_timer.sv
// Module: measures the acknowledgement listening window.
// Counts prescaled units while run is high; expire pulses in the last cycle
// of unit number 'delay' (window = (delay+1)*TICKS_PER_UNIT cycles).
// Assumes: run drops for at least one cycle between windows (clears count).
module arq_window_timer #(
    parameter int TICKS_PER_UNIT = 4000,
    parameter int DLY_W          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DLY_W-1:0] delay,
    output logic             expire
);
    localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_UNIT - 1);

    logic [PW-1:0]    pre_q;
    logic [DLY_W-1:0] unit_q;

    // Advance the prescaler and unit counter while the window runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q  <= '0;
            unit_q <= unit_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    // Flag the final cycle of the configured window.
    always_comb begin
        expire = run && (pre_q == PRE_LAST) && (unit_q == delay);
    end
endmodule

// File: rtl/arq_retry_ctr.sv
// Module: per-payload resend counter.
// Counts resends; at_limit is high once the count equals the configured limit.
// Assumes: clear and inc are never requested together.
module arq_retry_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit
);
    logic [CNT_W-1:0] cnt_q;

    // Track resends made for the current payload.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare the count with the configured limit.
    always_comb begin
        at_limit = (cnt_q == limit);
    end
endmodule

// File: rtl/arq_w1c_flags.sv
// Module: bank of write-1-to-clear status flags with an active-low summary.
// A set request wins over a clear request in the same cycle.
// Assumes: set and clr are single-cycle requests.
module arq_w1c_flags #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set,
    input  logic [NUM-1:0] clr,
    output logic [NUM-1:0] q,
    output logic           any_n
);
    for (genvar i = 0; i < NUM; i++) begin : g_flag
        // Hold one flag until software clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

    // Drive the summary line low while any flag is set.
    always_comb begin
        any_n = ~(|q);
    end
endmodule

// File: rtl/arq_tx_ctrl.sv
// Module: acknowledged transmit retry controller (top).
// Starts a send for the queue head, listens for a matching acknowledgement,
// resends on timeout up to the limit, then raises sent or max-retry flags.
// Assumes: modem_done arrives once per modem_send; head_valid reflects pops
// in the cycle after fifo_pop.
module arq_tx_ctrl
    import arq_pkg::*;
#(
    parameter int ADDR_W         = 40,
    parameter int TICKS_PER_UNIT = 4000,
    parameter int DLY_W          = 4,
    parameter int CNT_W          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              autoack_en,
    input  logic              head_valid,
    output logic              fifo_pop,
    input  logic [ADDR_W-1:0] tx_addr,
    output logic              modem_send,
    input  logic              modem_done,
    output logic              listen_on,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_addr,
    input  logic [DLY_W-1:0]  cfg_retry_delay,
    input  logic [CNT_W-1:0]  cfg_retry_count,
    input  logic              clr_sent,
    input  logic              clr_maxrt,
    output logic              flag_sent,
    output logic              flag_maxrt,
    output logic              irq_n
);
    arq_state_e          state_q, state_d;
    logic                ack_hit, done_noack, win_end, give_up, resend;
    logic                at_limit;
    logic [FLAG_NUM-1:0] flag_set, flag_clr, flag_q;

    // Step the transmit sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode events of the current cycle.
    always_comb begin
        ack_hit    = (state_q == ST_LISTEN) && ack_valid && (ack_addr == tx_addr);
        done_noack = (state_q == ST_AIR) && modem_done && !autoack_en;
        give_up    = win_end && !ack_hit && at_limit;
        resend     = win_end && !ack_hit && !at_limit;
        fifo_pop   = ack_hit || done_noack;
        modem_send = (state_q == ST_SEND);
        listen_on  = (state_q == ST_LISTEN);
    end

    // Choose the next sequence state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tx_enable && head_valid && !flag_q[FLAG_MAXRT]) state_d = ST_SEND;
            ST_SEND:   state_d = ST_AIR;
            ST_AIR:    if (modem_done) state_d = autoack_en ? ST_LISTEN : ST_IDLE;
            ST_LISTEN: begin
                if (ack_hit || give_up) state_d = ST_IDLE;
                else if (resend)        state_d = ST_SEND;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    arq_window_timer #(
        .TICKS_PER_UNIT(TICKS_PER_UNIT),
        .DLY_W         (DLY_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (listen_on),
        .delay (cfg_retry_delay),
        .expire(win_end)
    );

    arq_retry_ctr #(
        .CNT_W(CNT_W)
    ) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (fifo_pop || give_up),
        .inc     (resend),
        .limit   (cfg_retry_count),
        .at_limit(at_limit)
    );

    // Route flag requests into the flag bank.
    always_comb begin
        flag_set             = '0;
        flag_clr             = '0;
        flag_set[FLAG_SENT]  = fifo_pop;
        flag_set[FLAG_MAXRT] = give_up;
        flag_clr[FLAG_SENT]  = clr_sent;
        flag_clr[FLAG_MAXRT] = clr_maxrt;
        flag_sent            = flag_q[FLAG_SENT];
        flag_maxrt           = flag_q[FLAG_MAXRT];
    end

    arq_w1c_flags #(
        .NUM(FLAG_NUM)
    ) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flag_set),
        .clr  (flag_clr),
        .q    (flag_q),
        .any_n(irq_n)
    );
endmodule

// File: rtl/arq_tx_ctrl_chk.sv
// Module: protocol checker bound to the acknowledged transmit controller.
// Assumes: reset is held for at least one clock edge at start.
module arq_tx_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic modem_send,
    input logic modem_done,
    input logic listen_on,
    input logic fifo_pop,
    input logic flag_sent,
    input logic flag_maxrt
);
    // R2
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(listen_on) |-> $past(modem_done));

    // R4
    sent_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_sent) |-> $past(fifo_pop));

    // R6
    maxrt_after_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_maxrt) |-> ($past(listen_on) && !$past(fifo_pop)));

    // R7
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        modem_send |-> !flag_maxrt);

    // R2
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({modem_send, listen_on}));
endmodule

bind arq_tx_ctrl arq_tx_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .modem_send(modem_send),
    .modem_done(modem_done),
    .listen_on (listen_on),
    .fifo_pop  (fifo_pop),
    .flag_sent (flag_sent),
    .flag_maxrt(flag_maxrt)
);

// File: tb/arq_tx_ctrl_test.sv
// Bench: plays modem, far end and transmit queue around arq_tx_ctrl.
module arq_tx_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 40;
    localparam int TICKS      = 3;
    localparam int MODEM_LAT  = 4;
    localparam int ACK_LAT    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_enable = 1'b0, autoack_en = 1'b1;
    logic          head_valid, fifo_pop, modem_send, listen_on;
    logic          modem_done = 1'b0, ack_valid = 1'b0;
    logic [AW-1:0] tx_addr = 40'hC3A5_1E7D_09;
    logic [AW-1:0] ack_addr = '0;
    logic [3:0]    cfg_retry_delay = 4'd0, cfg_retry_count = 4'd0;
    logic          clr_sent = 1'b0, clr_maxrt = 1'b0;
    logic          flag_sent, flag_maxrt, irq_n;

    int checks = 0, fails = 0;
    int pushed = 0, popped = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign head_valid = (pushed > popped);

    // Queue model: count pops seen at the edge.
    always @(posedge clk) if (rst_n && fifo_pop) popped <= popped + 1;

    arq_tx_ctrl #(.ADDR_W(AW), .TICKS_PER_UNIT(TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .autoack_en(autoack_en),
        .head_valid(head_valid), .fifo_pop(fifo_pop), .tx_addr(tx_addr),
        .modem_send(modem_send), .modem_done(modem_done), .listen_on(listen_on),
        .ack_valid(ack_valid), .ack_addr(ack_addr),
        .cfg_retry_delay(cfg_retry_delay), .cfg_retry_count(cfg_retry_count),
        .clr_sent(clr_sent), .clr_maxrt(clr_maxrt),
        .flag_sent(flag_sent), .flag_maxrt(flag_maxrt), .irq_n(irq_n));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected outcome: 1 = sent, 2 = max-retry.
    function automatic int exp_result(int ack_at, int cnt, bit aa);
        if (!aa) return 1;
        return (ack_at >= 1 && ack_at <= cnt + 1) ? 1 : 2;
    endfunction

    function automatic int exp_sends(int ack_at, int cnt, bit aa);
        if (!aa) return 1;
        return (ack_at >= 1 && ack_at <= cnt + 1) ? ack_at : cnt + 1;
    endfunction

    task automatic clear_flags();
        @(negedge clk);
        clr_sent = 1'b1; clr_maxrt = 1'b1;
        @(negedge clk);
        clr_sent = 1'b0; clr_maxrt = 1'b0;
    endtask

    // Respond as modem and far end until a flag rises.
    task automatic run_until_flag(input int ack_at, input bit bad_ack,
                                  output int sends, output int win, output int res);
        int done_cd = 0, listen_len = 0;
        sends = 0; win = 0; res = 0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            modem_done = 1'b0; ack_valid = 1'b0;
            if (!listen_on && listen_len > 0) begin
                if (win == 0) win = listen_len;
                listen_len = 0;
            end
            if (flag_sent)  begin res = 1; break; end
            if (flag_maxrt) begin res = 2; break; end
            if (done_cd > 0) begin
                done_cd--;
                if (done_cd == 0) modem_done = 1'b1;
            end
            if (modem_send) begin sends++; done_cd = MODEM_LAT; end
            if (listen_on) begin
                listen_len++;
                if (sends == ack_at && listen_len == ACK_LAT) begin
                    ack_valid = 1'b1; ack_addr = tx_addr;
                end else if (bad_ack && listen_len == 1) begin
                    ack_valid = 1'b1; ack_addr = tx_addr ^ {{(AW-1){1'b0}}, 1'b1};
                end
            end
        end
        @(negedge clk);
        modem_done = 1'b0; ack_valid = 1'b0;
    endtask

    // Hold enable with a kept payload and look for any send.
    task automatic stall_check(input string tag);
        int seen = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (modem_send) seen++;
        end
        chk(seen == 0, tag, "sends while max-retry set", seen, 0);
    endtask

    // One packet with given settings, checked against the model.
    task automatic trial(input int dly, input int cnt, input int ack_at,
                         input bit aa, input bit bad);
        int sends, win, res, p0;
        clear_flags();
        cfg_retry_delay = 4'(dly); cfg_retry_count = 4'(cnt); autoack_en = aa;
        p0 = popped;
        pushed++;
        tx_enable = 1'b1;
        run_until_flag(ack_at, bad, sends, win, res);
        chk(res == exp_result(ack_at, cnt, aa), "R4/R6", "outcome", res, exp_result(ack_at, cnt, aa));
        chk(sends == exp_sends(ack_at, cnt, aa), "R5_R12", "send count", sends, exp_sends(ack_at, cnt, aa));
        chk(popped - p0 == (res == 1 ? 1 : 0), "R4_R6", "pops", popped - p0, (res == 1 ? 1 : 0));
        chk(irq_n == 1'b0, "R8", "irq_n with flag", irq_n, 0);
        if (!aa) chk(win == 0, "R10", "listen window opened", win, 0);
        else if (ack_at != 1) chk(win == (dly + 1) * TICKS, "R2", "window length", win, (dly + 1) * TICKS);
        if (bad) chk(res == exp_result(ack_at, cnt, aa), "R3", "wrong-address ack outcome", res, exp_result(ack_at, cnt, aa));
        if (res == 2) begin
            stall_check("R7");
            p0 = popped;
            @(negedge clk); clr_maxrt = 1'b1;
            @(negedge clk); clr_maxrt = 1'b0;
            chk(flag_maxrt == 1'b0, "R9", "maxrt after clear", flag_maxrt, 0);
            chk(flag_sent == 1'b0, "R9", "sent untouched", flag_sent, 0);
            run_until_flag(1, 1'b0, sends, win, res);
            chk(res == 1 && sends == 1, "R7", "resume after clear", sends, 1);
            chk(popped - p0 == 1, "R7", "kept payload popped", popped - p0, 1);
        end
        tx_enable = 1'b0;
        clear_flags();
        chk(irq_n == 1'b1, "R8_R9", "irq_n after clear", irq_n, 1);
    endtask

    initial begin : main
        int sends, win, res, p0, got;
        // R13 reset state
        repeat (3) @(negedge clk);
        chk(!flag_sent && !flag_maxrt, "R13", "flags in reset", {flag_sent, flag_maxrt}, 0);
        chk(irq_n == 1'b1, "R13", "irq_n in reset", irq_n, 1);
        chk(!modem_send && !listen_on && !fifo_pop, "R13", "strobes in reset",
            {modem_send, listen_on, fifo_pop}, 0);
        rst_n = 1'b1;

        // R1: enable low blocks start
        pushed++;
        got = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (modem_send) got++;
        end
        chk(got == 0, "R1", "send with enable low", got, 0);
        cfg_retry_count = 4'd2; cfg_retry_delay = 4'd1;
        tx_enable = 1'b1;
        run_until_flag(1, 1'b0, sends, win, res);
        chk(res == 1 && sends == 1, "R1", "start once enabled", sends, 1);
        tx_enable = 1'b0;
        clear_flags();
        // R1: empty queue, enable high
        tx_enable = 1'b1; got = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (modem_send) got++;
        end
        chk(got == 0, "R1", "send with empty queue", got, 0);
        tx_enable = 1'b0;

        // R10: no auto-acknowledge
        trial(3, 3, 0, 1'b0, 1'b0);

        // R6: zero retries, then R12: second limit event gets full budget again
        trial(2, 0, 0, 1'b1, 1'b0);
        clear_flags();
        cfg_retry_count = 4'd2; cfg_retry_delay = 4'd0; autoack_en = 1'b1;
        pushed++; tx_enable = 1'b1;
        run_until_flag(0, 1'b0, sends, win, res);
        chk(res == 2 && sends == 3, "R6", "first limit event sends", sends, 3);
        @(negedge clk); clr_maxrt = 1'b1;
        @(negedge clk); clr_maxrt = 1'b0;
        run_until_flag(0, 1'b0, sends, win, res);
        chk(res == 2 && sends == 3, "R12", "sends after limit restart", sends, 3);
        @(negedge clk); clr_maxrt = 1'b1;
        @(negedge clk); clr_maxrt = 1'b0;
        run_until_flag(1, 1'b0, sends, win, res);
        chk(res == 1, "R12", "drain kept payload", res, 1);
        tx_enable = 1'b0;
        clear_flags();

        // R11: chained payloads
        p0 = popped; got = 0;
        cfg_retry_count = 4'd2; cfg_retry_delay = 4'd1; autoack_en = 1'b1;
        pushed += 3; tx_enable = 1'b1;
        begin
            int done_cd = 0, ll = 0;
            for (int cyc = 0; cyc < 3000 && popped - p0 < 3; cyc++) begin
                @(negedge clk);
                modem_done = 1'b0; ack_valid = 1'b0;
                if (done_cd > 0) begin
                    done_cd--;
                    if (done_cd == 0) modem_done = 1'b1;
                end
                if (modem_send) begin got++; done_cd = MODEM_LAT; end
                if (listen_on) begin
                    ll++;
                    if (ll == ACK_LAT) begin ack_valid = 1'b1; ack_addr = tx_addr; end
                end else ll = 0;
            end
            @(negedge clk);
            modem_done = 1'b0; ack_valid = 1'b0;
        end
        chk(popped - p0 == 3, "R11", "chained pops", popped - p0, 3);
        chk(got == 3, "R11", "chained sends", got, 3);
        tx_enable = 1'b0;
        clear_flags();

        // Random trials mixed with wrong-address decoys (R3)
        void'($urandom(32'd2024));
        for (int t = 0; t < 30; t++) begin
            int d, c, a;
            d = $urandom_range(0, 5);
            c = $urandom_range(0, 4);
            a = $urandom_range(0, c + 2);
            trial(d, c, a, 1'b1, 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule